// File: doc/BRIEF.md
# Phase-Shedding Power-Save Sequencer

This block is the digital sequencer of a multiphase voltage regulator with up to four phases. It takes 8-bit voltage-ID words. Each word carries a 7-bit voltage code and an active-low power-save flag. The block decides how many phases are switching and what reference code the DAC receives. The outputs are a per-phase enable vector that drives the tri-state controls, the present reference code, an output-off request, a step-done flag and a mode indication.

When power save is requested, the block drops phases one at a time until only phase 1 switches. Phase 1 is index 0 in the enable vector. When the request is withdrawn, the block brings the phases back one at a time. Every phase change waits for the rising edge of that phase's own PWM signal.

A new voltage code that arrives during power save makes the block leave power save completely, step to the new code, and then shed phases again. Words that arrive while a shed or restore sequence runs are held and are applied once the sequence ends.

Top module: `phs_shed_seq`

## Requirements
- R1: A word is `word_i[7:0]`. Bit 7 is an active-low power-save request (0 = enter, 1 = leave). Bits 6:0 are the voltage code. After reset, `mode_o` is 0 (normal), every populated phase is enabled, `vcode_o` is 0 and `off_o` is low.
- R2: Once power save is requested, enabled phases are dropped from the highest index downward until only index 0 remains. `mode_o` is 1 (shedding) during this sequence and 2 (power save) once only index 0 is enabled.
- R3: A phase changes state only at the clock edge that follows the cycle in which its own `pwm_i` bit is first seen high (low in the previous cycle). A PWM edge on any other phase has no effect.
- R4: When power save is released, phases are re-enabled from index 1 upward. `mode_o` is 3 (restoring) during this sequence and returns to 0 when every populated phase is enabled.
- R5: At most one enable bit changes per clock. The next phase in a sequence is handled only after the previous change has taken place.
- R6: `nph_i` (1 to 4) sets the number of populated phases, indices 0 to `nph_i`-1. Unpopulated phases are never enabled and are skipped in both sequences. With one phase populated, a power-save request goes straight to mode 2.
- R7: A word that arrives in power save with a different code and the flag still 0 causes three things in order: a full restore, a step to the new code, and a renewed shed.
- R8: In stepping mode (`mode_o` = 4), each `step_tick_i` pulse moves `vcode_o` by one toward the target. `step_done_o` is high while in mode 4 with the code equal to the target. Ticks outside mode 4 have no effect.
- R9: Codes 0x7C to 0x7F set `off_o` and leave the code and the target unchanged. Any other code clears `off_o`.
- R10: A word received in mode 1 or 3 is held and is acted on only after the running sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | A word is present on word_i this cycle |
| word_i | input | 8 | Flag bit 7, voltage code bits 6:0 |
| nph_i | input | 3 | Number of populated phases (static) |
| pwm_i | input | 4 | Per-phase PWM signals from the modulator |
| step_tick_i | input | 1 | Voltage step pacing pulse |
| ph_en_o | output | 4 | Per-phase enable (1 = switching, 0 = tri-state) |
| vcode_o | output | 7 | Present reference code |
| off_o | output | 1 | Output-off request |
| step_done_o | output | 1 | Target code reached while stepping |
| mode_o | output | 3 | 0 normal, 1 shedding, 2 power save, 3 restoring, 4 stepping |

## Verification
A word is registered at the first clock edge after it is presented, and `mode_o` reacts one edge later. The bench therefore checks the mode two edges after each word. An enable bit and `vcode_o` change at the edge that samples the PWM rise or the tick, so the bench checks them half a cycle after that edge. A wrong-phase PWM pulse is placed before each expected change, and the bench confirms the enable vector has not moved. The entry, restore, step and re-shed sequence is swept for every populated count from 1 to 4, with the expected enable vector computed from the count.

// File: rtl/phs_pkg.sv
package phs_pkg;
  typedef enum logic [2:0] {
    M_NORM  = 3'd0,
    M_SHED  = 3'd1,
    M_PSAVE = 3'd2,
    M_REST  = 3'd3,
    M_STEP  = 3'd4
  } mode_e;
endpackage

// File: rtl/phs_pwm_edge.sv
module phs_pwm_edge #(
  parameter int NPH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NPH-1:0] pwm_i,
  output logic [NPH-1:0] rise_o
);
  logic [NPH-1:0] pwm_q;

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pwm_q[g] <= 1'b0;
      else         pwm_q[g] <= pwm_i[g];
    end
    assign rise_o[g] = pwm_i[g] & ~pwm_q[g];
  end
endmodule

// File: rtl/phs_vstep.sv
module phs_vstep #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] tgt_i,
  output logic [CW-1:0] vcode_o,
  output logic          at_tgt_o
);
  logic [CW-1:0] vcode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vcode_q <= '0;
    else if (run_i && tick_i && vcode_q != tgt_i)
      vcode_q <= (vcode_q < tgt_i) ? vcode_q + 1'b1 : vcode_q - 1'b1;
  end

  assign vcode_o  = vcode_q;
  assign at_tgt_o = (vcode_q == tgt_i);

  // R8
  step_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcode_q != $past(vcode_q)) |-> ($past(run_i) && $past(tick_i)));
  // R8
  step_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcode_q != $past(vcode_q)) |->
      (vcode_q == $past(vcode_q) + 1'b1 || vcode_q == $past(vcode_q) - 1'b1));
endmodule

// File: rtl/phs_seq_fsm.sv
module phs_seq_fsm
  import phs_pkg::*;
#(
  parameter int NPH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NPH-1:0] pop_i,
  input  logic [NPH-1:0] rise_i,
  input  logic           want_ps_i,
  input  logic           need_step_i,
  output logic [NPH-1:0] en_o,
  output mode_e          mode_o
);
  localparam logic [NPH-1:0] ONE = NPH'(1);

  mode_e          mode_q, mode_n;
  logic [NPH-1:0] en_q, en_n, act, shed_sel, rest_sel;
  logic           all_on, only1;

  assign act    = en_q & pop_i;
  assign all_on = (act == pop_i);
  assign only1  = (act == ONE);

  // shed picks highest active index, restore picks lowest idle one; index 0 excluded
  always_comb begin
    shed_sel = '0;
    for (int i = 1; i < NPH; i++)
      if (act[i]) begin
        shed_sel    = '0;
        shed_sel[i] = 1'b1;
      end
    rest_sel = '0;
    for (int i = NPH - 1; i >= 1; i--)
      if (pop_i[i] && !en_q[i]) begin
        rest_sel    = '0;
        rest_sel[i] = 1'b1;
      end
  end

  always_comb begin
    mode_n = mode_q;
    en_n   = en_q;
    case (mode_q)
      M_NORM:
        if (need_step_i)    mode_n = M_STEP;
        else if (want_ps_i) mode_n = only1 ? M_PSAVE : M_SHED;
      M_STEP:
        if (!need_step_i) mode_n = M_NORM;
      M_SHED:
        if (shed_sel == '0) mode_n = M_PSAVE;
        else if (|(rise_i & shed_sel)) begin
          en_n = en_q & ~shed_sel;
          if ((act & ~shed_sel) == ONE) mode_n = M_PSAVE;
        end
      M_PSAVE:
        if (need_step_i || !want_ps_i) mode_n = all_on ? M_NORM : M_REST;
      M_REST:
        if (rest_sel == '0) mode_n = M_NORM;
        else if (|(rise_i & rest_sel)) begin
          en_n = en_q | rest_sel;
          if ((act | rest_sel) == pop_i) mode_n = M_NORM;
        end
      default: mode_n = M_NORM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_NORM;
      en_q   <= '1;
    end else begin
      mode_q <= mode_n;
      en_q   <= en_n;
    end
  end

  assign en_o   = act;
  assign mode_o = mode_q;

  // R5
  one_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(act ^ $past(act)) <= 1);
  // R2
  psave_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_PSAVE) |-> (act == ONE));
  // R3
  for (genvar g = 0; g < NPH; g++) begin : g_chk
    // R3
    shed_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(act[g]) |-> $past(rise_i[g]));
    // R3
    rest_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(act[g]) |-> $past(rise_i[g]));
  end
endmodule

// File: rtl/phs_shed_seq.sv
module phs_shed_seq
  import phs_pkg::*;
#(
  parameter int NPH = 4,
  parameter int CW  = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           word_valid_i,
  input  logic [CW:0]    word_i,
  input  logic [2:0]     nph_i,
  input  logic [NPH-1:0] pwm_i,
  input  logic           step_tick_i,
  output logic [NPH-1:0] ph_en_o,
  output logic [CW-1:0]  vcode_o,
  output logic           off_o,
  output logic           step_done_o,
  output logic [2:0]     mode_o
);
  localparam logic [CW-1:0] OFF_MIN = CW'((1 << CW) - 4);

  mode_e          mode;
  logic [NPH-1:0] pop, rise;
  logic [CW:0]    pend_w, sel_w;
  logic [CW-1:0]  tgt_q;
  logic           pend_v, want_ps_q, off_q, busy, take, at_tgt;

  always_comb begin
    pop = '0;
    for (int i = 0; i < NPH; i++) pop[i] = (i == 0) || (i < int'(nph_i));
  end

  assign busy  = (mode == M_SHED) || (mode == M_REST);
  assign sel_w = word_valid_i ? word_i : pend_w;
  assign take  = (word_valid_i || pend_v) && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v    <= 1'b0;
      pend_w    <= '0;
      want_ps_q <= 1'b0;
      off_q     <= 1'b0;
      tgt_q     <= '0;
    end else begin
      if (word_valid_i && busy) begin
        pend_v <= 1'b1;
        pend_w <= word_i;
      end else if (take) begin
        pend_v    <= 1'b0;
        want_ps_q <= ~sel_w[CW];
        if (sel_w[CW-1:0] >= OFF_MIN) off_q <= 1'b1;
        else begin
          off_q <= 1'b0;
          tgt_q <= sel_w[CW-1:0];
        end
      end
    end
  end

  phs_pwm_edge #(.NPH(NPH)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwm_i(pwm_i), .rise_o(rise)
  );

  phs_vstep #(.CW(CW)) u_step (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(mode == M_STEP), .tick_i(step_tick_i),
    .tgt_i(tgt_q), .vcode_o(vcode_o), .at_tgt_o(at_tgt)
  );

  phs_seq_fsm #(.NPH(NPH)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pop_i(pop), .rise_i(rise),
    .want_ps_i(want_ps_q), .need_step_i(!at_tgt), .en_o(ph_en_o), .mode_o(mode)
  );

  assign off_o       = off_q;
  assign step_done_o = (mode == M_STEP) && at_tgt;
  assign mode_o      = mode;

  // R9
  off_keeps_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !(word_valid_i && busy) && sel_w[CW-1:0] >= OFF_MIN) |=> $stable(tgt_q));
  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && busy) |=> ($stable(tgt_q) && $stable(want_ps_q)));
endmodule

// File: tb/phs_shed_seq_test.sv
`timescale 1ns/1ps
module phs_shed_seq_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       word_valid = 1'b0, step_tick = 1'b0;
  logic [7:0] word = '0;
  logic [2:0] nph = 3'd4;
  logic [3:0] pwm = '0;
  logic [3:0] ph_en;
  logic [6:0] vcode;
  logic       off, step_done;
  logic [2:0] mode;
  int errors = 0, checks = 0, exp_en = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phs_shed_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(word_valid), .word_i(word),
    .nph_i(nph), .pwm_i(pwm), .step_tick_i(step_tick), .ph_en_o(ph_en),
    .vcode_o(vcode), .off_o(off), .step_done_o(step_done), .mode_o(mode)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [7:0] w);
    word = w; word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic pulse(int i);
    pwm[i] = 1'b1;
    @(negedge clk);
    pwm[i] = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick();
    step_tick = 1'b1;
    @(negedge clk);
    step_tick = 1'b0;
  endtask

  // shed from highest populated index downward; wrong-phase pulse first each time
  task automatic shed_all(int n);
    for (int p = n - 1; p >= 1; p--) begin
      pulse(0);
      chk("R3 foreign edge during shed", ph_en, exp_en);
      pulse(p);
      exp_en &= ~(1 << p);
      chk("R2 shed order", ph_en, exp_en);
      chk("R2 shed mode", mode, (p == 1) ? 2 : 1);
    end
  endtask

  task automatic restore_all(int n, int final_mode);
    for (int p = 1; p < n; p++) begin
      pulse(0);
      chk("R3 foreign edge during restore", ph_en, exp_en);
      pulse(p);
      exp_en |= (1 << p);
      chk("R4 restore order", ph_en, exp_en);
      chk("R4 restore mode", mode, (p == n - 1) ? final_mode : 3);
    end
  endtask

  initial begin
    for (int n = 1; n <= 4; n++) begin
      nph = 3'(n);
      rst_n = 1'b0;
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
      exp_en = (1 << n) - 1;
      chk("R1 reset enables", ph_en, exp_en);
      chk("R1 reset mode", mode, 0);
      chk("R1 reset code", vcode, 0);
      chk("R1 reset off", off, 0);
      pwm = 4'hF; cyc(1); pwm = 4'h0; cyc(1);
      chk("R6 pwm in normal mode", ph_en, exp_en);
      tick();
      chk("R8 tick outside stepping", vcode, 0);

      send(8'h00);
      cyc(1);
      chk("R6 enter shed/psave", mode, (n > 1) ? 1 : 2);
      shed_all(n);
      chk("R2 power save reached", mode, 2);
      chk("R2 only phase 1", ph_en, 1);

      send(8'h03);
      cyc(1);
      if (n > 1) begin
        chk("R7 exit before step", mode, 3);
        restore_all(n, 4);
      end else cyc(1);
      chk("R7 stepping after restore", mode, 4);
      chk("R7 code held during restore", vcode, 0);
      chk("R6 all populated back", ph_en, (1 << n) - 1);
      for (int k = 1; k <= 3; k++) begin
        chk("R8 not done before target", step_done, 0);
        tick();
        chk("R8 one LSB per tick up", vcode, k);
      end
      chk("R8 done at target", step_done, 1);
      cyc(1);
      chk("R7 normal after step", mode, 0);
      cyc(1);
      chk("R7 re-shed", mode, (n > 1) ? 1 : 2);
      shed_all(n);
      chk("R7 power save again", ph_en, 1);

      send(8'h83);
      cyc(1);
      if (n > 1) begin
        chk("R4 release restores", mode, 3);
        restore_all(n, 0);
      end
      chk("R4 normal after restore", mode, 0);
      chk("R4 full enable", ph_en, (1 << n) - 1);

      send(8'hFD);
      chk("R9 off set", off, 1);
      cyc(1);
      chk("R9 no step on off code", mode, 0);
      chk("R9 code kept", vcode, 3);
      send(8'h81);
      chk("R9 off cleared", off, 0);
      cyc(1);
      chk("R8 step down start", mode, 4);
      tick();
      chk("R8 step down", vcode, 2);
      tick();
      chk("R8 step down target", vcode, 1);
      chk("R8 done down", step_done, 1);
      cyc(1);
      chk("R8 back to normal", mode, 0);

      if (n > 1) begin
        send(8'h01);
        cyc(1);
        chk("R10 shed begins", mode, 1);
        send(8'h81);
        chk("R10 held word no effect yet", mode, 1);
        shed_all(n);
        cyc(1);
        chk("R10 held word applied after shed", mode, 3);
        restore_all(n, 0);
        chk("R10 final normal", mode, 0);
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R5: sequence hung, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule